// File: doc/BRIEF.md
# Three-Wire Serial Byte Memory Target

This block is the device end of a three-wire serial memory holding 128 bytes. A host raises a select line, toggles a serial clock and moves bits on one data line. In this block that line is split into a data input, a data output and an output enable. Every transfer opens with a 24-bit address/command. The block decodes it strictly. A well-formed command starts either a single-byte access or a burst covering the whole array, as a read or as a write. Any malformed command locks the block out until select is dropped and raised again.

All serial inputs are synchronised to a fast system clock and their edges are detected there. Write bits are taken on the rising serial-clock edge. Read bits are launched on the falling edge, so the host samples them on the next rising edge. The storage is a plain register array that is cleared by the system reset.

Top module: `srm_target`

## Requirements
- R1: While `sel_i` is low the block is idle, `sdo_oe_o` is 0, and serial clocks have no effect on memory or on the outputs.
- R2: After `sel_i` rises, the first 24 rising `sclk_i` edges shift in three command bytes, each least significant bit first. Byte 1 is the opcode, byte 2 the address byte and byte 3 the mode byte.
- R3: The opcode must be exactly 0x9D (read) or 0x62 (write). Any other value locks the block until `sel_i` goes low and then high: no writes happen and `sdo_oe_o` stays 0 whatever follows.
- R4: Bits 6..0 of the address byte select one of 128 locations. Bit 7 must be 0, otherwise the block locks as in R3.
- R5: Bits 6..0 of the mode byte must all be 0, otherwise the block locks as in R3.
- R6: A mode byte with bit 7 set and an address of 0 selects burst: 128 consecutive bytes from location 0 upward. Clocks after the 128th byte are ignored and `sdo_oe_o` falls.
- R7: Every other valid command transfers exactly one byte of 8 data clocks. Clocks after it are ignored: no further location is written, and on a read `sdo_oe_o` falls at the next falling edge.
- R8: On a read, data bits are driven on `sdo_o`, least significant bit first, starting at the falling `sclk_i` edge after the 24th rising edge and advancing one bit per falling edge. `sdo_oe_o` is 1 while bits are driven.
- R9: On a write, data bits are sampled on rising `sclk_i` edges, least significant bit first. A byte is stored only once all 8 of its bits have arrived. A partial byte cut off by `sel_i` falling is discarded.
- R10: A mode byte with bit 7 set and a nonzero address performs a single-byte access at that address.
- R11: After `rst_ni` is asserted, `sdo_o` and `sdo_oe_o` are 0 and every location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Transfer select; rising edge starts a transfer, low aborts it |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Enable for the data-line driver |

## Verification
The bench targets the lockout paths. It sends a bad opcode, a set address bit 7 and nonzero mode bits, each followed by a complete write or read. A decoder that only warned, or that recovered mid-transfer, would corrupt the target location or drive the line. It clocks past the end of single and burst transfers: a counter that failed to stop would overwrite the next location, or wrap onto location 0, or keep driving. It drops select partway through a write byte, where a design that committed bits eagerly would store a torn value. It also uses the burst flag with a nonzero address, which a loose mode decoder would turn into a burst.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CMD_BITS = 3 * BYTE_W;
  localparam logic [7:0]  OP_READ  = 8'h9D;
  localparam logic [7:0]  OP_WRITE = 8'h62;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_LOCK,
    ST_END
  } srm_state_e;
endpackage

// File: rtl/srm_sync.sv
module srm_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/srm_store.sv
module srm_store #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/srm_ctrl.sv
module srm_ctrl
  import srm_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  input  logic [7:0]        rdata_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned CNT_W   = ADDR_W + 1;
  localparam logic [7:0]  HI_MASK = 8'hFF << ADDR_W;

  srm_state_e        state_q;
  logic              sel_q, sclk_q, is_wr_q;
  logic [4:0]        bit_cnt_q;
  logic [6:0]        byte_sr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;

  logic       sclk_rise, sclk_fall, last_bit;
  logic [7:0] byte_full;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign sclk_fall = ~sclk_i & sclk_q;
  assign byte_full = {sdi_i, byte_sr_q};
  assign last_bit  = (bit_cnt_q[2:0] == 3'd7);

  assign we_o    = sel_i && sel_q && (state_q == ST_WR) && sclk_rise && last_bit;
  assign wdata_o = byte_full;
  assign addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sel_q     <= 1'b0;
      sclk_q    <= 1'b0;
      is_wr_q   <= 1'b0;
      bit_cnt_q <= '0;
      byte_sr_q <= '0;
      addr_q    <= '0;
      left_q    <= '0;
      sdo_o     <= 1'b0;
      sdo_oe_o  <= 1'b0;
    end else begin
      sel_q  <= sel_i;
      sclk_q <= sclk_i;
      if (!sel_i) begin
        state_q  <= ST_IDLE;
        sdo_oe_o <= 1'b0;
        sdo_o    <= 1'b0;
      end else if (!sel_q) begin
        state_q   <= ST_CMD;
        bit_cnt_q <= '0;
        byte_sr_q <= '0;
        left_q    <= '0;
      end else begin
        unique case (state_q)
          ST_CMD: if (sclk_rise) begin
            byte_sr_q <= byte_full[7:1];
            bit_cnt_q <= bit_cnt_q + 5'd1;
            if (last_bit) begin
              unique case (bit_cnt_q[4:3])
                2'd0: begin
                  if (byte_full == OP_READ) is_wr_q <= 1'b0;
                  else if (byte_full == OP_WRITE) is_wr_q <= 1'b1;
                  else state_q <= ST_LOCK;
                end
                2'd1: begin
                  addr_q <= byte_full[ADDR_W-1:0];
                  if ((byte_full & HI_MASK) != '0) state_q <= ST_LOCK;
                end
                default: begin
                  if (byte_full[6:0] != '0) begin
                    state_q <= ST_LOCK;
                  end else begin
                    state_q   <= is_wr_q ? ST_WR : ST_RD;
                    bit_cnt_q <= '0;
                    // burst only on flag plus address zero
                    left_q    <= (byte_full[7] && addr_q == '0) ? CNT_W'(DEPTH)
                                                                : CNT_W'(1);
                  end
                end
              endcase
            end
          end
          ST_WR: if (sclk_rise) begin
            byte_sr_q <= byte_full[7:1];
            bit_cnt_q <= bit_cnt_q + 5'd1;
            if (last_bit) begin
              bit_cnt_q <= '0;
              addr_q    <= addr_q + 1'b1;
              left_q    <= left_q - 1'b1;
              if (left_q == CNT_W'(1)) state_q <= ST_END;
            end
          end
          ST_RD: if (sclk_fall) begin
            if (left_q == '0) begin
              sdo_oe_o <= 1'b0;
              state_q  <= ST_END;
            end else begin
              sdo_o     <= rdata_i[bit_cnt_q[2:0]];
              sdo_oe_o  <= 1'b1;
              bit_cnt_q <= bit_cnt_q + 5'd1;
              if (last_bit) begin
                bit_cnt_q <= '0;
                addr_q    <= addr_q + 1'b1;
                left_q    <= left_q - 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_sel_low_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (state_q == ST_IDLE && !sdo_oe_o));

  assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCK && sel_i && sel_q) |=> state_q == ST_LOCK);

  assert_oe_in_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> state_q == ST_RD);

  assert_burst_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= CNT_W'(DEPTH));

  assert_write_counted_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> left_q != '0);
endmodule

// File: rtl/srm_target.sv
module srm_target #(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic [2:0]        pins_s;
  logic              we;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata, rdata;

  srm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sel_i, sclk_i, sdi_i}),
    .q_o    (pins_s)
  );

  srm_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (pins_s[2]),
    .sclk_i   (pins_s[1]),
    .sdi_i    (pins_s[0]),
    .we_o     (we),
    .addr_o   (addr),
    .wdata_o  (wdata),
    .rdata_i  (rdata),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
  );

  srm_store #(.ADDR_W(ADDR_W), .DATA_W(8)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );
endmodule

// File: tb/test_srm_target.sv
module test_srm_target;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  int   total = 0, bad = 0;
  logic [7:0] model [128];

  always #2 clk = ~clk;

  srm_target i_srm_target (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .sclk_i(sclk),
    .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  function automatic logic [23:0] cmd24(bit wr, logic [7:0] addr_byte, logic [7:0] mode);
    return {mode, addr_byte, wr ? 8'h62 : 8'h9D};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    sclk = 1'b1; repeat (4) @(negedge clk);
    sclk = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(logic [23:0] v, int n);
    for (int i = 0; i < n; i++) begin sdi = v[i]; pulse(); end
  endtask

  task automatic start();
    sel = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic stop();
    sel = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic read_byte(output logic [7:0] v, input string req);
    for (int i = 0; i < 8; i++) begin
      chk(sdo_oe === 1'b1, req, sdo_oe, 1);
      v[i] = sdo;
      pulse();
    end
  endtask

  task automatic write_single(logic [6:0] a, logic [7:0] d);
    start(); send_bits(cmd24(1, {1'b0, a}, 8'h00), 24); send_bits({16'h0, d}, 8); stop();
    model[a] = d;
  endtask

  task automatic read_single(logic [6:0] a, string req);
    logic [7:0] v;
    start(); send_bits(cmd24(0, {1'b0, a}, 8'h00), 24);
    read_byte(v, req);
    chk(v === model[a], req, v, model[a]);
    chk(sdo_oe === 1'b0, {req, " R7 oe after byte"}, sdo_oe, 0);
    stop();
  endtask

  task automatic read_burst(string req);
    logic [7:0] v;
    start(); send_bits(cmd24(0, 8'h00, 8'h80), 24);
    for (int b = 0; b < 128; b++) begin
      read_byte(v, req);
      if (v !== model[b]) chk(1'b0, req, v, model[b]);
    end
    chk(1'b1, req, 0, 0);
    chk(sdo_oe === 1'b0, "R6 oe after burst", sdo_oe, 0);
    stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk(sdo_oe === 1'b0 && sdo === 1'b0, "R11 outputs after reset", {sdo_oe, sdo}, 0);
    read_single(7'd5, "R11 location clear");

    // R2 R8 R9 directed and random single accesses
    write_single(7'd3, 8'hB4);
    read_single(7'd3, "R2 R8 R9 directed");
    for (int k = 0; k < 12; k++) begin
      logic [6:0] a = 7'($urandom());
      logic [7:0] d = 8'($urandom());
      write_single(a, d);
      read_single(a, "R9 random write/read");
    end

    // R1 clocks while select low do nothing
    for (int i = 0; i < 32; i++) begin sdi = 1'b1; pulse(); end
    chk(sdo_oe === 1'b0, "R1 idle oe", sdo_oe, 0);
    read_single(7'd3, "R1 memory untouched");

    // R7 extra clocks after a single write
    write_single(7'd40, 8'h11);
    write_single(7'd41, 8'h22);
    start(); send_bits(cmd24(1, 8'd40, 8'h00), 24); send_bits(24'h00CC33, 16); stop();
    model[40] = 8'h33;
    read_single(7'd40, "R7 single write");
    read_single(7'd41, "R7 next location kept");

    // R3 bad opcode, then rest of a write command and data
    start(); send_bits({8'h00, 8'd41, 8'h63}, 24); send_bits(24'h0000FF, 8);
    chk(sdo_oe === 1'b0, "R3 lockout oe", sdo_oe, 0);
    stop();
    read_single(7'd41, "R3 lockout no write");
    start(); send_bits({8'h00, 8'd41, 8'h9C}, 24);
    for (int i = 0; i < 4; i++) pulse();
    chk(sdo_oe === 1'b0, "R3 near-read lockout oe", sdo_oe, 0);
    stop();

    // R4 address byte bit 7 set
    start(); send_bits(cmd24(1, 8'h80 | 8'd41, 8'h00), 24); send_bits(24'h000099, 8); stop();
    read_single(7'd41, "R4 lockout no write");

    // R5 mode byte low bits nonzero
    start(); send_bits(cmd24(1, 8'd41, 8'h01), 24); send_bits(24'h000099, 8); stop();
    read_single(7'd41, "R5 lockout no write");
    start(); send_bits(cmd24(0, 8'd41, 8'h40), 24); pulse();
    chk(sdo_oe === 1'b0, "R5 lockout read oe", sdo_oe, 0);
    stop();
    write_single(7'd41, 8'h5A);
    read_single(7'd41, "R3 recovered after reselect");

    // R10 burst flag with nonzero address
    write_single(7'd10, 8'h01);
    start(); send_bits(cmd24(1, 8'd9, 8'h80), 24); send_bits(24'h00E7D2, 16); stop();
    model[9] = 8'hD2;
    read_single(7'd9, "R10 single at address");
    read_single(7'd10, "R10 no second byte");

    // R9 partial byte discarded
    write_single(7'd20, 8'h0F);
    start(); send_bits(cmd24(1, 8'd20, 8'h00), 24); send_bits(24'h0000F0, 5); stop();
    read_single(7'd20, "R9 partial discarded");

    // R1 select drop mid-read
    start(); send_bits(cmd24(0, 8'd20, 8'h00), 24); pulse(); pulse();
    sel = 1'b0; repeat (4) @(negedge clk);
    chk(sdo_oe === 1'b0, "R1 oe after select drop", sdo_oe, 0);

    // R6 burst write with trailing byte, then burst read
    start(); send_bits(cmd24(1, 8'h00, 8'h80), 24);
    for (int b = 0; b < 128; b++) begin
      logic [7:0] d = 8'($urandom());
      model[b] = d;
      send_bits({16'h0, d}, 8);
    end
    send_bits(24'h0000A5 ^ {16'h0, model[0]} ^ 24'h0000FF, 8);
    stop();
    read_burst("R6 burst contents");
    read_single(7'd0, "R6 no wrap write");

    // R8 explicit bit order on one byte
    write_single(7'd77, 8'b0000_0001);
    start(); send_bits(cmd24(0, 8'd77, 8'h00), 24);
    chk(sdo === 1'b1 && sdo_oe === 1'b1, "R8 first bit is LSB", sdo, 1);
    read_byte(v, "R8 bit order");
    chk(v === 8'h01, "R8 bit order value", v, 8'h01);
    stop();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule